// File: doc/BRIEF.md
# Bridge Fault Supervisor with Diagnostic Encoder

This block gathers already-synchronized fault bits from the analog monitors of a motor-bridge driver. It decides whether the four bridge gate drivers may run, whether the external controller must be held in reset, and what the three diagnostic pins show. The inputs are: supply overvoltage, battery undervoltage, supply undervoltage, short circuit, charge-pump failure, three temperature comparator levels, and the watchdog's trigger indications.

Temperature uses hysteresis. A shutdown starts when the shutdown comparator fires. It ends only once the shutdown comparator is low and the "cooled below recovery" comparator is high. Every shutdown is recorded on the third diagnostic line. That record stays set through recovery and clears only on the first watchdog trigger after recovery. All inputs pass through one register stage and all outputs are registered, so every output follows its inputs with a fixed latency of two clock edges.

Top module: `fault_diag_supervisor`

## Requirements
- R1: `bridge_en` is 1 only when `wd_ok_in` is 1, none of `ov_in`, `bat_uv_in`, `sup_uv_in`, `short_in` is 1, and no thermal shutdown is active; `cpf_in` and `t_warn_in` have no effect on it.
- R2: `diag1` is the OR of `short_in` and `sup_uv_in`.
- R3: `diag2` is the OR of `ov_in`, `bat_uv_in` and `cpf_in`.
- R4: Outside a shutdown and with no recorded shutdown, `diag3` equals `t_warn_in`.
- R5: While a thermal shutdown is active, `reset_req` is 1 and both `bridge_en` and `tx_en` are 0; otherwise `reset_req` is 0 and `tx_en` is 1.
- R6: A shutdown starts when `t_shut_in` is 1. It persists until `t_shut_in` is 0 and `t_cool_in` is 1 in the same cycle; with both low it holds.
- R7: A shutdown sets a record that drives `diag3` high. The record clears on a trigger seen while no shutdown is active. A trigger is a rising edge of `wd_ok_in` or a one-cycle high on `wd_pulse_in`. Triggers during a shutdown are ignored.
- R8: An input change held stable appears at the outputs after the second rising clock edge.
- R9: While `rst_n` is low, all outputs are 0 and the shutdown record is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_in | input | 1 | Supply overvoltage |
| bat_uv_in | input | 1 | Battery undervoltage |
| sup_uv_in | input | 1 | Bridge supply undervoltage |
| short_in | input | 1 | Short circuit detected |
| cpf_in | input | 1 | Charge-pump failure |
| t_warn_in | input | 1 | Temperature above warning level |
| t_shut_in | input | 1 | Temperature above shutdown level |
| t_cool_in | input | 1 | Temperature below recovery level |
| wd_ok_in | input | 1 | Watchdog trigger accepted (level) |
| wd_pulse_in | input | 1 | Watchdog trigger pulse |
| bridge_en | output | 1 | Global bridge driver enable |
| tx_en | output | 1 | Serial transmitter enable |
| reset_req | output | 1 | Reset request to controller |
| diag1 | output | 1 | Diagnostic line 1 |
| diag2 | output | 1 | Diagnostic line 2 |
| diag3 | output | 1 | Diagnostic line 3 |

## Verification
The hardest state to reach is a shutdown record that survives recovery while a trigger arrives. Two conditions make it hard. The watchdog level must make a fresh rising edge after the temperature has passed through the hysteresis band, and a trigger issued during the shutdown must be shown to leave the record intact. The stimulus first sweeps every combination of the non-thermal flags. It then walks the temperature inputs through shutdown, the in-between band and recovery. Along the way it drops and raises the watchdog level and fires pulses both during and after the shutdown.

// File: rtl/fault_diag_supervisor.sv
module fault_diag_supervisor (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_in,
  input  logic bat_uv_in,
  input  logic sup_uv_in,
  input  logic short_in,
  input  logic cpf_in,
  input  logic t_warn_in,
  input  logic t_shut_in,
  input  logic t_cool_in,
  input  logic wd_ok_in,
  input  logic wd_pulse_in,
  output logic bridge_en,
  output logic tx_en,
  output logic reset_req,
  output logic diag1,
  output logic diag2,
  output logic diag3
);

  logic ov_q, bu_q, su_q, sc_q, cp_q, tw_q, ts_q, tc_q, wk_q, wp_q, wk_d;
  logic shut_st, ot_lat;
  logic trig, shut_nx, lat_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ov_q, bu_q, su_q, sc_q, cp_q} <= '0;
      {tw_q, ts_q, tc_q, wk_q, wp_q, wk_d} <= '0;
    end else begin
      ov_q <= ov_in;
      bu_q <= bat_uv_in;
      su_q <= sup_uv_in;
      sc_q <= short_in;
      cp_q <= cpf_in;
      tw_q <= t_warn_in;
      ts_q <= t_shut_in;
      tc_q <= t_cool_in;
      wk_q <= wd_ok_in;
      wp_q <= wd_pulse_in;
      wk_d <= wk_q;
    end
  end

  assign trig    = (wk_q & ~wk_d) | wp_q;
  assign shut_nx = shut_st ? ~(tc_q & ~ts_q) : ts_q;
  assign lat_nx  = shut_nx | (ot_lat & ~trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_st   <= 1'b0;
      ot_lat    <= 1'b0;
      bridge_en <= 1'b0;
      tx_en     <= 1'b0;
      reset_req <= 1'b0;
      diag1     <= 1'b0;
      diag2     <= 1'b0;
      diag3     <= 1'b0;
    end else begin
      shut_st   <= shut_nx;
      ot_lat    <= lat_nx;
      bridge_en <= wk_q & ~sc_q & ~su_q & ~ov_q & ~bu_q & ~shut_nx;
      tx_en     <= ~shut_nx;
      reset_req <= shut_nx;
      diag1     <= sc_q | su_q;
      diag2     <= ov_q | bu_q | cp_q;
      diag3     <= tw_q | lat_nx;
    end
  end

  assert_fault_blocks_bridge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sc_q | su_q | ov_q | bu_q | ~wk_q) |-> !bridge_en);

  assert_diag1_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sc_q | su_q) |-> diag1);

  assert_warn_shows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tw_q) |-> diag3);

  assert_shutdown_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (!bridge_en && !tx_en));

  assert_recover_needs_cool_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_req) |-> $past(tc_q && !ts_q));

  assert_record_clears_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(diag3) |-> !reset_req);

endmodule

// File: tb/tb_fault_diag_supervisor.sv
module tb_fault_diag_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ov_in = 0, bat_uv_in = 0, sup_uv_in = 0, short_in = 0, cpf_in = 0;
  logic t_warn_in = 0, t_shut_in = 0, t_cool_in = 1, wd_ok_in = 0, wd_pulse_in = 0;
  logic bridge_en, tx_en, reset_req, diag1, diag2, diag3;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_diag_supervisor dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(input string req, input logic en, input logic tx,
                           input logic rr, input logic d1, input logic d2, input logic d3);
    chk({req, " bridge_en"}, bridge_en, en);
    chk({req, " tx_en"}, tx_en, tx);
    chk({req, " reset_req"}, reset_req, rr);
    chk({req, " diag1"}, diag1, d1);
    chk({req, " diag2"}, diag2, d2);
    chk({req, " diag3"}, diag3, d3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R9 reset", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 sweep of all non-thermal flag combinations
    for (int i = 0; i < 128; i++) begin
      logic [6:0] v;
      v = i[6:0];
      {wd_ok_in, t_warn_in, cpf_in, short_in, sup_uv_in, bat_uv_in, ov_in} = v;
      settle();
      check_all("R1/R2/R3/R4 sweep",
                v[6] & ~v[3] & ~v[2] & ~v[1] & ~v[0], 1'b1, 1'b0,
                v[3] | v[2], v[0] | v[1] | v[4], v[5]);
    end

    {wd_ok_in, t_warn_in, cpf_in, short_in, sup_uv_in, bat_uv_in, ov_in} = 7'b1000000;
    settle();
    check_all("R1 clean", 1, 1, 0, 0, 0, 0);

    // R8: latency of exactly two edges
    short_in = 1'b1;
    @(negedge clk);
    chk("R8 no change after one edge", diag1, 1'b0);
    @(negedge clk);
    chk("R8 change after two edges", diag1, 1'b1);
    short_in = 1'b0;
    settle();

    // R5: enter shutdown
    t_warn_in = 1; t_shut_in = 1; t_cool_in = 0;
    settle();
    check_all("R5 shutdown", 0, 0, 1, 0, 0, 1);

    // R7: trigger pulse during shutdown ignored
    wd_pulse_in = 1; @(negedge clk); wd_pulse_in = 0;
    settle();
    chk("R7 pulse during shutdown", diag3, 1'b1);

    // R6: hysteresis band holds shutdown
    t_warn_in = 0; t_shut_in = 0; t_cool_in = 0;
    repeat (5) @(negedge clk);
    check_all("R6 band holds", 0, 0, 1, 0, 0, 1);

    // R6: recovery
    t_cool_in = 1;
    settle();
    check_all("R6 recovered R7 record kept", 1, 1, 0, 0, 0, 1);

    // R7: level low then rising edge clears
    wd_ok_in = 0;
    settle();
    chk("R7 level low keeps record", diag3, 1'b1);
    chk("R1 no trigger level", bridge_en, 1'b0);
    wd_ok_in = 1;
    settle();
    check_all("R7 rising edge clears", 1, 1, 0, 0, 0, 0);

    // R7: second shutdown, cleared by pulse after recovery
    t_shut_in = 1; t_cool_in = 0;
    settle();
    chk("R5 second shutdown", reset_req, 1'b1);
    t_shut_in = 0; t_cool_in = 1;
    settle();
    chk("R7 record after second recovery", diag3, 1'b1);
    chk("R5 released", reset_req, 1'b0);
    wd_pulse_in = 1; @(negedge clk); wd_pulse_in = 0;
    settle();
    chk("R7 pulse clears", diag3, 1'b0);

    // R6: shutdown wins over cool when both high
    t_shut_in = 1; t_cool_in = 1;
    settle();
    chk("R6 shut with cool", reset_req, 1'b1);
    t_shut_in = 0;
    settle();
    chk("R6 leave when shut low and cool", reset_req, 1'b0);

    // R4: warning alone keeps bridge running
    wd_pulse_in = 1; @(negedge clk); wd_pulse_in = 0;
    t_warn_in = 1;
    settle();
    check_all("R4 warning only", 1, 1, 0, 0, 0, 1);
    t_warn_in = 0;
    settle();
    chk("R4 warning gone", diag3, 1'b0);

    // R9: reset in the middle of a shutdown
    t_shut_in = 1; t_cool_in = 0;
    settle();
    rst_n = 0;
    @(negedge clk);
    check_all("R9 reset during shutdown", 0, 0, 0, 0, 0, 0);
    t_shut_in = 0; t_cool_in = 1;
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R9 record cleared by reset", diag3, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule